// File: doc/BRIEF.md
# Split Shift-and-Add Pointer Unit

This block forms a 64-bit pointer sum from two halves that cooperate. The second operand is shifted left by a small immediate (0 to 7 places) and added to the first operand. A low half adds the low words. It hands its carry, the bits pushed out of the top of the shifted low word, the shift amount and a sign-fill bit to a high half over an internal sideband. The high half then adds the upper words. Both halves take the same issue. The 64-bit result is registered and appears one cycle after the issue.

The second operand can be taken three ways. It can be a full 64-bit value. It can be a 32-bit value zero-extended to 64 bits. It can be a 32-bit value sign-extended to 64 bits. In the two 32-bit modes the upper word of the second operand plays no part. The sum wraps modulo 2^64 and no overflow indication is produced. This suits address generation, where an index is scaled by an element size and added to a base pointer.

Top module: `ptr_shadd`

## Requirements
- R1: During and after a synchronous reset, and before any issue, `res_valid` is 0 and `res_lo`/`res_hi` are 0.
- R2: `res_valid` is high exactly one cycle after an issue (`op_valid` high). `res_lo`/`res_hi` change only on the cycle after an issue and otherwise hold their value.
- R3: With `op_mode` = 0 (full 64-bit), the result is {a_hi,a_lo} + ({b_hi,b_lo} << shamt) modulo 2^64, for every shamt from 0 to 7.
- R4: In every mode, the `shamt` most significant bits of `b_lo` that the shift pushes out of the low word land in bit positions [shamt-1:0] of the shifted upper word.
- R5: A carry out of the low 32-bit add is added into the upper word.
- R6: With `op_mode` = 1 (zero-extend), the second operand is {32'b0,b_lo}, and `b_hi` has no effect on the result.
- R7: With `op_mode` = 2 (sign-extend), the second operand is b_lo sign-extended to 64 bits before shifting. A negative b_lo therefore fills the upper word with ones. `b_hi` has no effect.
- R8: `op_mode` = 3 behaves exactly like zero-extend mode.
- R9: The result wraps modulo 2^64 with no flag. For example, all-ones plus one gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe for both halves |
| op_mode | input | 2 | 0 full 64-bit, 1 zero-extend, 2 sign-extend, 3 as 1 |
| op_shamt | input | 3 | Left shift applied to the second operand |
| a_lo | input | 32 | First operand, low word |
| a_hi | input | 32 | First operand, high word |
| b_lo | input | 32 | Second operand, low word (or the 32-bit value) |
| b_hi | input | 32 | Second operand, high word (used only in mode 0) |
| res_valid | output | 1 | Result valid, one cycle after issue |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word |

## Verification
The bench builds the block with its default widths: 32-bit words and a 3-bit shift, so the sideband carries up to seven spill bits. At these widths a 64-bit reference model in the bench can compute every expected sum directly. Every shift amount from 0 to 7 can be swept in each mode. The cases where the spill and the carry meet can also be reached directly: a full-ones low word, a negative 32-bit value shifted by 7, and wrap-around of the whole 64-bit sum.

// File: rtl/ptr_shadd_pkg.sv
package ptr_shadd_pkg;

    parameter int WORD_W  = 32;
    parameter int SHAMT_W = 3;
    localparam int SPILL_W = (1 << SHAMT_W) - 1;
    localparam int FULL_W  = 2 * WORD_W;

    typedef enum logic [1:0] {
        MODE_WIDE = 2'd0,
        MODE_ZEXT = 2'd1,
        MODE_SEXT = 2'd2
    } ext_mode_e;

    // Private link from the low half to the high half
    typedef struct packed {
        logic               carry;
        logic               fill;
        logic               wide;
        logic [SPILL_W-1:0] spill;
        logic [SHAMT_W-1:0] shamt;
    } link_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } word_pair_t;

    function automatic ext_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd0:    decode_mode = MODE_WIDE;
            2'd2:    decode_mode = MODE_SEXT;
            default: decode_mode = MODE_ZEXT;
        endcase
    endfunction

endpackage

// File: rtl/ptr_shadd_low.sv
module ptr_shadd_low
    import ptr_shadd_pkg::*;
(
    input  logic [WORD_W-1:0]  a_lo,
    input  logic [WORD_W-1:0]  b_lo,
    input  logic [SHAMT_W-1:0] shamt,
    input  ext_mode_e          mode,
    output logic [WORD_W-1:0]  sum_lo,
    output link_t              link
);

    logic [WORD_W+SPILL_W-1:0] b_shifted;
    logic [WORD_W:0]           lo_full;

    always_comb begin
        b_shifted   = {{SPILL_W{1'b0}}, b_lo} << shamt;
        lo_full     = {1'b0, a_lo} + {1'b0, b_shifted[WORD_W-1:0]};
        sum_lo      = lo_full[WORD_W-1:0];
        link.carry  = lo_full[WORD_W];
        link.spill  = b_shifted[WORD_W+SPILL_W-1:WORD_W];
        link.shamt  = shamt;
        link.wide   = (mode == MODE_WIDE);
        link.fill   = (mode == MODE_SEXT) & b_lo[WORD_W-1];
    end

    // Spill bits above the shift amount must stay clear (R4)
    always_comb begin
        p_spill_clean_r4: assert ((link.spill >> shamt) == '0)
            else $error("spill has bits beyond shift amount");
        p_carry_wrap_r5: assert (link.carry == (sum_lo < a_lo))
            else $error("carry disagrees with low-word wrap");
    end

endmodule

// File: rtl/ptr_shadd_high.sv
module ptr_shadd_high
    import ptr_shadd_pkg::*;
(
    input  logic [WORD_W-1:0] a_hi,
    input  logic [WORD_W-1:0] b_hi,
    input  link_t             link,
    output logic [WORD_W-1:0] sum_hi
);

    logic [WORD_W-1:0] b_src;
    logic [WORD_W-1:0] b_up;

    always_comb begin
        b_src  = link.wide ? b_hi : {WORD_W{link.fill}};
        b_up   = (b_src << link.shamt)
               | {{(WORD_W-SPILL_W){1'b0}}, link.spill};
        sum_hi = a_hi + b_up + {{(WORD_W-1){1'b0}}, link.carry};
    end

    // Sign fill only ever comes from a narrow mode (R7)
    always_comb begin
        p_fill_narrow_r7: assert (!(link.fill && link.wide))
            else $error("sign fill raised in full-width mode");
    end

endmodule

// File: rtl/ptr_shadd.sv
module ptr_shadd
    import ptr_shadd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [1:0]         op_mode,
    input  logic [SHAMT_W-1:0] op_shamt,
    input  logic [WORD_W-1:0]  a_lo,
    input  logic [WORD_W-1:0]  a_hi,
    input  logic [WORD_W-1:0]  b_lo,
    input  logic [WORD_W-1:0]  b_hi,
    output logic               res_valid,
    output logic [WORD_W-1:0]  res_lo,
    output logic [WORD_W-1:0]  res_hi
);

    ext_mode_e  mode;
    link_t      link;
    word_pair_t sum_now;
    word_pair_t sum_q;

    assign mode = decode_mode(op_mode);

    ptr_shadd_low u_low (
        .a_lo   (a_lo),
        .b_lo   (b_lo),
        .shamt  (op_shamt),
        .mode   (mode),
        .sum_lo (sum_now.lo),
        .link   (link)
    );

    ptr_shadd_high u_high (
        .a_hi   (a_hi),
        .b_hi   (b_hi),
        .link   (link),
        .sum_hi (sum_now.hi)
    );

    // Both halves are captured on the same issue edge
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            sum_q     <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) sum_q <= sum_now;
        end
    end

    assign res_lo = sum_q.lo;
    assign res_hi = sum_q.hi;

    p_issue_lat_r2: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);
    p_idle_lat_r2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(res_lo) && $stable(res_hi)));
    p_zero_narrow_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_mode != 2'd0 && b_lo == '0)
        |=> ({res_hi, res_lo} == $past({a_hi, a_lo})));

endmodule

// File: tb/ptr_shadd_tb.sv
`timescale 1ns/1ps
module ptr_shadd_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_mode = 2'd0;
    logic [2:0]  op_shamt = 3'd0;
    logic [31:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
    logic        res_valid;
    logic [31:0] res_lo, res_hi;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_res = '0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    ptr_shadd u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_mode(op_mode),
        .op_shamt(op_shamt), .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo),
        .b_hi(b_hi), .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi)
    );

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one issue per call, expected value from a 64-bit model
    task automatic issue(input string tag, input logic [1:0] m,
                         input logic [2:0] sh, input logic [63:0] a,
                         input logic [63:0] b);
        logic [63:0] bext;
        @(negedge clk);
        op_valid = 1'b1; op_mode = m; op_shamt = sh;
        a_lo = a[31:0]; a_hi = a[63:32]; b_lo = b[31:0]; b_hi = b[63:32];
        case (m)
            2'd0:    bext = b;
            2'd2:    bext = {{32{b[31]}}, b[31:0]};
            default: bext = {32'b0, b[31:0]};
        endcase
        exp_q.push_back(a + (bext << sh));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            b_lo = 32'hA5A5_5A5A; a_lo = 32'h1234_5678;
        end
    endtask

    // Monitor: compare each result against the scoreboard, check hold
    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected result", 64'd1, 64'd0);
                end else begin
                    check(tag_q.pop_front(), {res_hi, res_lo}, exp_q.pop_front());
                end
                last_res = {res_hi, res_lo};
            end else if (!done) begin
                if ({res_hi, res_lo} !== last_res)
                    check("R2 hold while idle", {res_hi, res_lo}, last_res);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, res_valid}, 64'd0);
        check("R1 reset result", {res_hi, res_lo}, 64'd0);
        @(negedge clk); rst = 1'b0;
        idle(2);
        check("R1 idle after reset", {63'd0, res_valid}, 64'd0);

        issue("R3 wide simple", 2'd0, 3'd0, 64'h0000_0001_0000_0002,
              64'h0000_0003_0000_0004);
        idle(2);
        check("R2 hold count", {res_hi, res_lo}, 64'h0000_0004_0000_0006);
        for (int s = 0; s < 8; s++)
            issue("R3 wide sweep", 2'd0, 3'(s), 64'h1357_9BDF_2468_ACE0,
                  64'hF0E1_D2C3_B4A5_9687);
        issue("R4 spill into high", 2'd0, 3'd3, 64'd0, 64'h0000_0000_E000_0000);
        issue("R4 spill narrow", 2'd1, 3'd7, 64'd0, 64'h0000_0000_FF00_0001);
        issue("R5 carry into high", 2'd0, 3'd0, 64'h0000_0010_FFFF_FFFF, 64'd1);
        issue("R5 carry with shift", 2'd0, 3'd4, 64'h0000_0000_F000_0000,
              64'h0000_0000_0100_0000);
        issue("R6 zext ignores b_hi", 2'd1, 3'd2, 64'h0000_0002_0000_0000,
              64'hDEAD_BEEF_8000_0000);
        for (int s = 0; s < 8; s++)
            issue("R6 zext sweep", 2'd1, 3'(s), 64'h0F0F_0F0F_F0F0_F0F0,
                  64'h1111_1111_9ABC_DEF0);
        issue("R7 sext negative sh7", 2'd2, 3'd7, 64'd0, 64'hFFFF_0000_8000_0000);
        issue("R7 sext minus one", 2'd2, 3'd0, 64'h0000_0005_0000_0000,
              64'h1234_5678_FFFF_FFFF);
        issue("R7 sext positive", 2'd2, 3'd1, 64'd7, 64'hFFFF_FFFF_7FFF_FFFF);
        for (int s = 0; s < 8; s++)
            issue("R7 sext sweep", 2'd2, 3'(s), 64'h8000_0000_0000_0100,
                  64'h0BAD_F00D_C001_D00D);
        issue("R8 mode3 as zext", 2'd3, 3'd5, 64'h0000_0001_0000_0001,
              64'hFFFF_FFFF_8765_4321);
        issue("R9 wrap to zero", 2'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        issue("R9 wrap shifted", 2'd2, 3'd7, 64'h0000_0000_0000_0080,
              64'h0000_0000_FFFF_FFFF);
        idle(4);
        done = 1'b1;
        check("R2 queue drained", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule